// File: doc/BRIEF.md
# Dual-Register Programmable Logic Macrocell

This block models one output cell of a sum-of-products programmable logic device. The block receives product-term results that the AND array has already evaluated. Twelve upper terms are ORed in groups of four into three sum terms. Configuration inputs decide how these sum terms are shared between the pin path and two flip-flops. Each flip-flop can act as a D or a T register. Each has its own clock term and its own clear term, and each can optionally gate its clock term with a dedicated clock pin.

The cell drives a pin value with its enable, and it returns six feedback bits to the array. The pin value comes either from the first register or straight from the output sum, and a polarity input chooses its sense. The buried second register can be bypassed, so that its sum input rather than its state is fed back. A synchronous preset line, shared by a group of cells, forces both registers high on their next clock.

In this synchronous model a clock term acts as a per-register enable, sampled on the system clock. A clear term is sampled on the same edge and overrides everything else.

Top module: `pld_macrocell`

## Requirements
- R1: The three sum terms are A = OR of pt_sum[3:0], B = OR of pt_sum[7:4] and C = OR of pt_sum[11:8]. The output sum is chosen by cfg_split: code 0 gives A|B (8 terms), code 1 gives A alone (4 terms), code 2 gives A|B|C (12 terms), and code 3 behaves as code 0.
- R2: The second register's input is always C. When cfg_fb_dt=1, fb_bus[5] carries C (bypassed register). When cfg_fb_dt=0, it carries Q2.
- R3: A register with type bit 0 (D) that is clocked without clear or preset loads its input, and the new value is visible one system clock later.
- R4: A register with type bit 1 (T) that is clocked without clear or preset inverts its state when its input is 1 and holds it when its input is 0.
- R5: A clock-select bit of 0 clocks the register whenever its clock term is 1. A value of 1 clocks it only when both the clock term and pin_clk are 1. With no clock, the register holds its state.
- R6: A clear term at 1 (pt_ar1 for Q1, pt_ar2 for Q2) sets that register to 0 at the next edge, whatever the clock, preset, type or input.
- R7: When a register is clocked and its clear term is 0, sync_preset=1 sets it to 1 regardless of its type and input.
- R8: With cfg_comb=0 the pin value is Q1, and with cfg_comb=1 it is the output sum. pin_out equals that value when cfg_pol=1 and its inverse when cfg_pol=0.
- R9: pin_oe follows pt_oe in the same cycle.
- R10: fb_bus, from bit 5 down to bit 0, is {F2, ~F2, Q1, ~Q1, pin_in, ~pin_in}.
- R11: While rst_n=0 both registers are 0, so pin_out in registered mode is 0 when cfg_pol=1 and 1 when cfg_pol=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which both registers are sampled |
| rst_n | input | 1 | Active-low power-up reset, clears both registers |
| pt_sum | input | 12 | Upper product-term results, four per sum term |
| pt_ar1 | input | 1 | Clear term for register 1 |
| pt_ck1 | input | 1 | Clock term for register 1 |
| pt_ck2 | input | 1 | Clock term for register 2 |
| pt_ar2 | input | 1 | Clear term for register 2 |
| pt_oe | input | 1 | Output-enable term |
| pin_clk | input | 1 | Dedicated clock pin level |
| sync_preset | input | 1 | Shared group preset |
| pin_in | input | 1 | Level read back from the I/O pin |
| cfg_split | input | 2 | Sum-term split code |
| cfg_comb | input | 1 | 1 selects the combinational pin path |
| cfg_fb_dt | input | 1 | 1 feeds back the register-2 input instead of Q2 |
| cfg_t1 | input | 1 | Register 1 type, 0 D, 1 T |
| cfg_t2 | input | 1 | Register 2 type, 0 D, 1 T |
| cfg_ck1_pin | input | 1 | Register 1 clock gated by pin_clk |
| cfg_ck2_pin | input | 1 | Register 2 clock gated by pin_clk |
| cfg_pol | input | 1 | Pin polarity, 1 active-high |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin tristate enable |
| fb_bus | output | 6 | Feedback bits to the array |

## Verification
The routing, polarity, enable and feedback results settle in the same cycle as their inputs. The bench therefore changes those inputs and samples them 1 ns later, with no clock edge between. Register results are due one system clock after the inputs that cause them. The bench applies each stimulus 1 ns after a rising edge and compares 1 ns after the next rising edge. It predicts the register state in its own model from the priority order of clear, clock, preset and type.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  // Output sum selection from the split code
  function automatic logic route_out(input logic [1:0] split,
                                     input logic sa, input logic sb,
                                     input logic sc);
    case (split)
      2'd1:    route_out = sa;
      2'd2:    route_out = sa | sb | sc;
      default: route_out = sa | sb;
    endcase
  endfunction

  // Register update in priority order: clear, hold, preset, D/T
  function automatic logic flop_next(input logic clr, input logic en,
                                     input logic preset, input logic ttype,
                                     input logic d, input logic q);
    if (clr)         flop_next = 1'b0;
    else if (!en)    flop_next = q;
    else if (preset) flop_next = 1'b1;
    else if (ttype)  flop_next = q ^ d;
    else             flop_next = d;
  endfunction

endpackage

// File: rtl/mc_sum_router.sv
module mc_sum_router #(
  parameter int PT_PER_SUM = 4,
  parameter int NUM_SUMS   = 3
) (
  input  logic [NUM_SUMS*PT_PER_SUM-1:0] pt,
  input  logic [1:0]                     split,
  output logic                           out_sum,
  output logic                           reg2_sum
);
  import pld_mc_pkg::*;

  logic [NUM_SUMS-1:0] sum_term;

  for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
    assign sum_term[g] = |pt[g*PT_PER_SUM +: PT_PER_SUM];
  end

  assign out_sum  = route_out(split, sum_term[0], sum_term[1], sum_term[NUM_SUMS-1]);
  assign reg2_sum = sum_term[NUM_SUMS-1];

  // R1
  always_comb begin
    full_merge_chk: assert (split != 2'd2 || out_sum == (|pt));
  end

endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_pt,
  input  logic ck_pt,
  input  logic pin_clk,
  input  logic ck_sel,
  input  logic preset,
  input  logic ttype,
  input  logic d,
  output logic q
);
  import pld_mc_pkg::*;

  logic clk_en;
  assign clk_en = ck_pt & (ck_sel ? pin_clk : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flop_next(clr_pt, clk_en, preset, ttype, d, q);
  end

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pt |=> (q == 1'b0));

  // R7
  preset_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_pt && ck_pt && !ck_sel && preset) |=> q);

  // R5
  no_clock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_pt && !ck_pt) |=> $stable(q));

  // R4
  t_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_pt && clk_en && !preset && ttype && d) |=> (q != $past(q)));

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int PT_PER_SUM = 4,
  localparam int NUM_SUMS  = 3,
  localparam int NUM_PT    = NUM_SUMS * PT_PER_SUM,
  localparam int FB_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PT-1:0] pt_sum,
  input  logic              pt_ar1,
  input  logic              pt_ck1,
  input  logic              pt_ck2,
  input  logic              pt_ar2,
  input  logic              pt_oe,
  input  logic              pin_clk,
  input  logic              sync_preset,
  input  logic              pin_in,
  input  logic [1:0]        cfg_split,
  input  logic              cfg_comb,
  input  logic              cfg_fb_dt,
  input  logic              cfg_t1,
  input  logic              cfg_t2,
  input  logic              cfg_ck1_pin,
  input  logic              cfg_ck2_pin,
  input  logic              cfg_pol,
  output logic              pin_out,
  output logic              pin_oe,
  output logic [FB_W-1:0]   fb_bus
);

  logic out_sum, reg2_sum;
  logic [1:0] clr_v, ck_v, sel_v, type_v, d_v, q_v;
  logic f2, pin_val;

  mc_sum_router #(.PT_PER_SUM(PT_PER_SUM), .NUM_SUMS(NUM_SUMS)) u_router (
    .pt       (pt_sum),
    .split    (cfg_split),
    .out_sum  (out_sum),
    .reg2_sum (reg2_sum)
  );

  assign clr_v  = {pt_ar2, pt_ar1};
  assign ck_v   = {pt_ck2, pt_ck1};
  assign sel_v  = {cfg_ck2_pin, cfg_ck1_pin};
  assign type_v = {cfg_t2, cfg_t1};
  assign d_v    = {reg2_sum, out_sum};

  for (genvar r = 0; r < 2; r++) begin : g_reg
    mc_flop u_flop (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_pt  (clr_v[r]),
      .ck_pt   (ck_v[r]),
      .pin_clk (pin_clk),
      .ck_sel  (sel_v[r]),
      .preset  (sync_preset),
      .ttype   (type_v[r]),
      .d       (d_v[r]),
      .q       (q_v[r])
    );
  end

  assign f2      = cfg_fb_dt ? reg2_sum : q_v[1];
  assign pin_val = cfg_comb ? out_sum : q_v[0];
  assign pin_out = cfg_pol ? pin_val : ~pin_val;
  assign pin_oe  = pt_oe;
  assign fb_bus  = {f2, ~f2, q_v[0], ~q_v[0], pin_in, ~pin_in};

  // R8
  registered_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comb && cfg_pol) |-> (pin_out == fb_bus[3]));

endmodule

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] pt_sum;
  logic        pt_ar1, pt_ck1, pt_ck2, pt_ar2, pt_oe;
  logic        pin_clk, sync_preset, pin_in;
  logic [1:0]  cfg_split;
  logic        cfg_comb, cfg_fb_dt, cfg_t1, cfg_t2;
  logic        cfg_ck1_pin, cfg_ck2_pin, cfg_pol;
  logic        pin_out, pin_oe;
  logic [5:0]  fb_bus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] rs = 32'h1234_5679;
  logic eq1, eq2;

  always #2 clk = ~clk;

  pld_macrocell uut (
    .clk(clk), .rst_n(rst_n), .pt_sum(pt_sum), .pt_ar1(pt_ar1),
    .pt_ck1(pt_ck1), .pt_ck2(pt_ck2), .pt_ar2(pt_ar2), .pt_oe(pt_oe),
    .pin_clk(pin_clk), .sync_preset(sync_preset), .pin_in(pin_in),
    .cfg_split(cfg_split), .cfg_comb(cfg_comb), .cfg_fb_dt(cfg_fb_dt),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_ck1_pin(cfg_ck1_pin),
    .cfg_ck2_pin(cfg_ck2_pin), .cfg_pol(cfg_pol),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_bus(fb_bus)
  );

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // Expected output sum, restated from the split table
  function automatic logic exp_out(input logic [11:0] p, input logic [1:0] s);
    logic a, b, c;
    a = p[0] | p[1] | p[2] | p[3];
    b = p[4] | p[5] | p[6] | p[7];
    c = p[8] | p[9] | p[10] | p[11];
    if (s == 2'd1) return a;
    if (s == 2'd2) return a | b | c;
    return a | b;
  endfunction

  function automatic logic exp_c(input logic [11:0] p);
    return p[11:8] != 4'd0;
  endfunction

  function automatic logic [5:0] exp_fb(input logic f2, input logic q1, input logic pi);
    return {f2, !f2, q1, !q1, pi, !pi};
  endfunction

  function automatic string reg_tag(input logic clr, input logic en,
                                    input logic pre, input logic t);
    if (clr) return "R6";
    if (!en) return "R5";
    if (pre) return "R7";
    if (t)   return "R4";
    return "R3";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pt_sum = '0; pt_ar1 = 0; pt_ck1 = 0; pt_ck2 = 0; pt_ar2 = 0; pt_oe = 0;
    pin_clk = 0; sync_preset = 0; pin_in = 0; cfg_split = 0; cfg_comb = 0;
    cfg_fb_dt = 0; cfg_t1 = 0; cfg_t2 = 0; cfg_ck1_pin = 0; cfg_ck2_pin = 0;
    cfg_pol = 1;
    #9;
    // R11: reset state in both polarities
    check("R11 pin pol=1", {5'd0, pin_out}, 6'd0);
    check("R11 fb", fb_bus, exp_fb(1'b0, 1'b0, 1'b0));
    cfg_pol = 0; #1;
    check("R11 pin pol=0", {5'd0, pin_out}, 6'd1);
    pt_oe = 1; #1;
    check("R9 oe high", {5'd0, pin_oe}, 6'd1);
    pt_oe = 0; #1;
    check("R9 oe low", {5'd0, pin_oe}, 6'd0);
    pin_in = 1; #1;
    check("R10 pin_in", fb_bus, exp_fb(1'b0, 1'b0, 1'b1));
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R8: exhaustive combinational sweep, registers left unclocked
    cfg_comb = 1; cfg_fb_dt = 1;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4096; p++) begin
        for (int pol = 0; pol < 2; pol++) begin
          cfg_split = s[1:0]; pt_sum = p[11:0]; cfg_pol = pol[0];
          #1;
          check("R1 R8 comb pin", {5'd0, pin_out},
                {5'd0, pol[0] ? exp_out(p[11:0], s[1:0]) : !exp_out(p[11:0], s[1:0])});
          if (pol == 0)
            check("R2 dt feedback", {5'd0, fb_bus[5]}, {5'd0, exp_c(p[11:0])});
        end
      end
    end

    // Register state is still the reset value: no clock term was active
    cfg_comb = 0; cfg_fb_dt = 0; cfg_pol = 1; #1;
    check("R5 held through sweep", fb_bus, exp_fb(1'b0, 1'b0, 1'b1));

    // R3 R4 R5 R6 R7 R8 R10: pseudo-random register sequence with a bench model
    @(posedge clk); #1;
    eq1 = 1'b0; eq2 = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      logic en1, en2, d1, d2, n1, n2, pv, f2;
      rs = xs(rs);
      pt_sum = rs[11:0];
      cfg_split = rs[13:12];
      pt_ar1 = (rs[16:14] == 3'd0);
      pt_ar2 = (rs[19:17] == 3'd0);
      pt_ck1 = rs[20]; pt_ck2 = rs[21]; pin_clk = rs[22];
      cfg_ck1_pin = rs[23]; cfg_ck2_pin = rs[24];
      sync_preset = (rs[27:25] == 3'd0);
      cfg_t1 = rs[28]; cfg_t2 = rs[29]; cfg_pol = rs[30]; pin_in = rs[31];
      rs = xs(rs);
      cfg_comb = (rs[2:0] == 3'd0); cfg_fb_dt = (rs[4:3] == 2'd0);
      pt_oe = rs[5];
      en1 = pt_ck1 & (!cfg_ck1_pin | pin_clk);
      en2 = pt_ck2 & (!cfg_ck2_pin | pin_clk);
      d1 = exp_out(pt_sum, cfg_split);
      d2 = exp_c(pt_sum);
      if (pt_ar1) n1 = 0; else if (!en1) n1 = eq1; else if (sync_preset) n1 = 1;
      else n1 = cfg_t1 ? (eq1 ^ d1) : d1;
      if (pt_ar2) n2 = 0; else if (!en2) n2 = eq2; else if (sync_preset) n2 = 1;
      else n2 = cfg_t2 ? (eq2 ^ d2) : d2;
      @(posedge clk); #1;
      eq1 = n1; eq2 = n2;
      check({reg_tag(pt_ar1, en1, sync_preset, cfg_t1), " reg1"},
            {5'd0, fb_bus[3]}, {5'd0, eq1});
      if (!cfg_fb_dt)
        check({reg_tag(pt_ar2, en2, sync_preset, cfg_t2), " reg2"},
              {5'd0, fb_bus[5]}, {5'd0, eq2});
      pv = cfg_comb ? d1 : eq1;
      f2 = cfg_fb_dt ? d2 : eq2;
      check("R8 pin", {5'd0, pin_out}, {5'd0, cfg_pol ? pv : !pv});
      check("R10 fb", fb_bus, exp_fb(f2, eq1, pin_in));
      check("R9 oe", {5'd0, pin_oe}, {5'd0, pt_oe});
    end

    // R11: reset asserted again clears both registers
    cfg_comb = 0; cfg_fb_dt = 0; cfg_pol = 0; pt_ar1 = 0; pt_ar2 = 0;
    rst_n = 1'b0; #1;
    check("R11 reassert pin", {5'd0, pin_out}, 6'd1);
    check("R11 reassert q2", {5'd0, fb_bus[5]}, 6'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule